// File: doc/BRIEF.md
# Embedded Program/Erase Engine with Status Polling

This block is the device-side executor behind a flash command decoder. Once a command sequence has been decoded, the decoder hands the engine a one-cycle start request carrying an operation kind, a target address and a data byte. The engine then runs a byte program, a sector erase or a whole-array erase against a behavioural byte array. Each kind of operation takes a fixed number of clock cycles, and every duration is a parameter. Programming can only clear bits. Erase writes all-ones over a region picked from a fixed sector map. A lockout input protects the top (boot) region.

While an operation runs, reads do not return array contents. A read returns a status byte instead. Bit 7 is the polling bit: during a program it is the inverse of the bit being written, and during an erase it is 0. Bit 6 changes value on every accepted read. Host software waits for bit 6 to stop toggling, or for bit 7 to show the final data, and then reads real data. The sector map scales with the address width. The top five address bits select one of five regions in the same proportions as a 256 KiB array: two small parameter regions and a boot region at the top, and two main regions below them.

Top module: `flash_op_engine`

## Requirements
- R1: A synchronous active-low reset clears busy, clears rd_data to 0x00 and ends any operation in flight without changing the array.
- R2: When idle, a start pulse is accepted with op_kind 00 = byte program, 01 = sector erase or 10 = chip erase. Code 11 is not accepted. busy is high from the next cycle for exactly PROG_CYCLES (program) or ERASE_CYCLES (erase) cycles.
- R3: A start pulse that arrives while busy has no effect. It changes neither the running operation, its duration nor the array.
- R4: A byte program stores the old byte ANDed with op_data at op_addr. Addresses may be programmed in any order and in any region.
- R5: A read accepted during a program returns bit 7 equal to the inverse of bit 7 of the data being programmed.
- R6: A read accepted during any erase, including a rejected one, returns bit 7 = 0.
- R7: A read accepted while busy returns {poll bit, toggle bit, 6'b000000}. The first such read after a start returns toggle 0, and each later one returns the inverse of the one before.
- R8: rd_data is updated on the clock edge that samples rd_en, and holds its value otherwise. A read sampled on the edge where the operation completes still returns status. The next read returns the updated array byte.
- R9: Sector map, with u = the top five address bits: u >= 30 is boot, u = 29 is parameter 1, u = 28 is parameter 2, 16..27 is main 1, and 0..15 is main 2. A sector erase sets every byte of the region holding op_addr to 0xFF and leaves every other region unchanged.
- R10: If boot_lock is high, a sector erase that targets the boot region keeps busy high for REJECT_CYCLES cycles and changes no byte.
- R11: A chip erase sets every byte to 0xFF. The exception is that boot-region bytes are left unchanged if boot_lock was high when the erase was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | One-cycle start request from the command decoder |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase |
| op_addr | input | ADDR_W | Program address, or any address in the sector to erase |
| op_data | input | 8 | Program data |
| boot_lock | input | 1 | Boot-region erase lockout |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte, or status byte while busy |
| busy | output | 1 | Operation in progress |

## Verification
Two things can land on the same clock edge: the completion of an operation, which writes the array and drops busy, and an accepted read. The bench strobes a read on every cycle after a program starts, so one of those reads is sampled on the completion edge. That read must still show the status byte with its alternating toggle bit, and the read that follows must show the ANDed byte. A second collision is a start request issued one cycle into an erase. It is judged by the total busy length and by the array contents at the address it named. Randomised programs and erases are checked against a bench model of the array, and full-array sweeps are compared after every erase.

// File: rtl/flash_op_pkg.sv
// Shared types for the program/erase engine: operation codes, the region
// encoding, and the function that maps address bits to a region.
package flash_op_pkg;

    typedef enum logic [1:0] {
        OP_PROG  = 2'b00,
        OP_SECT  = 2'b01,
        OP_CHIP  = 2'b10,
        OP_NONE  = 2'b11
    } op_kind_t;

    typedef enum logic [2:0] {
        SEC_MAIN_LO = 3'd0,
        SEC_MAIN_HI = 3'd1,
        SEC_PARAM_B = 3'd2,
        SEC_PARAM_A = 3'd3,
        SEC_BOOT    = 3'd4
    } sector_t;

    // Region of an address, given its top five bits (32 equal slices).
    function automatic sector_t sector_of(input logic [4:0] slice);
        if (slice >= 5'd30)      return SEC_BOOT;
        else if (slice == 5'd29) return SEC_PARAM_A;
        else if (slice == 5'd28) return SEC_PARAM_B;
        else if (slice >= 5'd16) return SEC_MAIN_HI;
        else                     return SEC_MAIN_LO;
    endfunction

endpackage

// File: rtl/flash_op_sequencer.sv
// Operation sequencer. It accepts a start request when idle, latches the
// operation, and counts down its duration. On the final cycle it raises a
// commit strobe. Assumes every duration parameter is at least 1.
module flash_op_sequencer
    import flash_op_pkg::*;
#(
    parameter int ADDR_W        = 10,
    parameter int PROG_CYCLES   = 6,
    parameter int ERASE_CYCLES  = 20,
    parameter int REJECT_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_kind_t          req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              boot_lock,
    output logic              busy,
    output logic              accept,
    output logic              commit,
    output op_kind_t          run_kind,
    output logic [ADDR_W-1:0] run_addr,
    output logic [7:0]        run_data,
    output logic              run_reject,
    output logic              run_lock
);
    localparam int MAX_A   = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int MAX_DUR = (MAX_A > REJECT_CYCLES) ? MAX_A : REJECT_CYCLES;
    localparam int CNT_W   = $clog2(MAX_DUR + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] dur_m1;
    logic             req_reject;

    // Decide whether a request is taken and whether it is a locked boot erase.
    always_comb begin
        accept     = start && !busy && (req_kind != OP_NONE);
        req_reject = (req_kind == OP_SECT) && boot_lock &&
                     (sector_of(req_addr[ADDR_W-1 -: 5]) == SEC_BOOT);
        if (req_kind == OP_PROG) dur_m1 = CNT_W'(PROG_CYCLES - 1);
        else if (req_reject)     dur_m1 = CNT_W'(REJECT_CYCLES - 1);
        else                     dur_m1 = CNT_W'(ERASE_CYCLES - 1);
    end

    // Latch the operation and run its countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cnt_q      <= '0;
            run_kind   <= OP_PROG;
            run_addr   <= '0;
            run_data   <= '0;
            run_reject <= 1'b0;
            run_lock   <= 1'b0;
        end else if (accept) begin
            busy       <= 1'b1;
            cnt_q      <= dur_m1;
            run_kind   <= req_kind;
            run_addr   <= req_addr;
            run_data   <= req_data;
            run_reject <= req_reject;
            run_lock   <= boot_lock;
        end else if (busy) begin
            if (cnt_q == '0) busy  <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // Commit on the last busy cycle. Gated by reset so that an abort never writes.
    assign commit = busy && (cnt_q == '0) && rst_n;

endmodule

// File: rtl/flash_cell_array.sv
// Behavioural byte array. A program ANDs new data into one byte. An erase
// sets every byte of the selected region, or of the whole array, to 0xFF.
// Contents are not reset, which models non-volatile storage.
module flash_cell_array
    import flash_op_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              prog_en,
    input  logic              erase_en,
    input  logic              erase_chip,
    input  logic              skip_boot,
    input  sector_t           tgt_sec,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cell_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
        localparam sector_t           SEC = sector_of(IDX[ADDR_W-1 -: 5]);
        logic [7:0] q;
        logic       hit;

        // Does the current erase cover this byte?
        always_comb begin
            if (erase_chip) hit = !(skip_boot && (SEC == SEC_BOOT));
            else            hit = (SEC == tgt_sec);
        end

        // Store one byte: programming clears bits, erasing sets them.
        always_ff @(posedge clk) begin
            if (prog_en && (wr_addr == IDX)) q <= q & wr_data;
            else if (erase_en && hit)        q <= 8'hFF;
        end

        assign cell_q[g] = q;
    end

    assign rd_byte = cell_q[rd_addr];

endmodule

// File: rtl/flash_status_mux.sv
// Read port. Returns the array byte when idle. While busy it returns a
// status byte with a polling bit (7) and a toggle bit (6). The toggle bit
// flips once per accepted read and is cleared when an operation starts.
module flash_status_mux
    import flash_op_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       accept,
    input  logic       rd_en,
    input  op_kind_t   run_kind,
    input  logic       run_bit7,
    input  logic [7:0] array_byte,
    output logic [7:0] rd_data
);
    logic toggle_q;
    logic poll_bit;

    // Polling bit: inverted data bit for program, zero for any erase.
    assign poll_bit = (run_kind == OP_PROG) ? !run_bit7 : 1'b0;

    // Toggle state and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            toggle_q <= 1'b0;
            rd_data  <= 8'h00;
        end else begin
            if (accept)              toggle_q <= 1'b0;
            else if (rd_en && busy)  toggle_q <= !toggle_q;
            if (rd_en) rd_data <= busy ? {poll_bit, toggle_q, 6'b000000} : array_byte;
        end
    end

endmodule

// File: rtl/flash_op_engine.sv
// Top of the program/erase engine. Joins the sequencer, the byte array and
// the read/status port. Assumes ADDR_W >= 5, so that the region map can use
// the top five address bits.
module flash_op_engine
    import flash_op_pkg::*;
#(
    parameter int ADDR_W        = 10,
    parameter int PROG_CYCLES   = 6,
    parameter int ERASE_CYCLES  = 20,
    parameter int REJECT_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic              boot_lock,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    logic              accept;
    logic              commit;
    op_kind_t          run_kind;
    logic [ADDR_W-1:0] run_addr;
    logic [7:0]        run_data;
    logic              run_reject;
    logic              run_lock;
    logic [7:0]        array_byte;
    logic              prog_en;
    logic              erase_en;
    sector_t           tgt_sec;

    flash_op_sequencer #(
        .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES), .REJECT_CYCLES(REJECT_CYCLES)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .start(op_start),
        .req_kind(op_kind_t'(op_kind)), .req_addr(op_addr), .req_data(op_data),
        .boot_lock(boot_lock), .busy(busy), .accept(accept), .commit(commit),
        .run_kind(run_kind), .run_addr(run_addr), .run_data(run_data),
        .run_reject(run_reject), .run_lock(run_lock)
    );

    // Split the commit strobe into a program write or an erase write.
    always_comb begin
        prog_en  = commit && (run_kind == OP_PROG);
        erase_en = commit && (run_kind != OP_PROG) && !run_reject;
        tgt_sec  = sector_of(run_addr[ADDR_W-1 -: 5]);
    end

    flash_cell_array #(.ADDR_W(ADDR_W)) i_array (
        .clk(clk), .prog_en(prog_en), .erase_en(erase_en),
        .erase_chip(run_kind == OP_CHIP), .skip_boot(run_lock),
        .tgt_sec(tgt_sec), .wr_addr(run_addr), .wr_data(run_data),
        .rd_addr(rd_addr), .rd_byte(array_byte)
    );

    flash_status_mux i_status (
        .clk(clk), .rst_n(rst_n), .busy(busy), .accept(accept), .rd_en(rd_en),
        .run_kind(run_kind), .run_bit7(run_data[7]),
        .array_byte(array_byte), .rd_data(rd_data)
    );

endmodule

// File: rtl/flash_op_checker.sv
// Protocol checker for the program/erase engine, bound to the top module.
module flash_op_checker
    import flash_op_pkg::*;
#(
    parameter int PROG_CYCLES   = 6,
    parameter int ERASE_CYCLES  = 20,
    parameter int REJECT_CYCLES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       op_start,
    input logic [1:0] op_kind,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       busy,
    input op_kind_t   run_kind,
    input logic       run_bit7
);
    localparam int MAX_A   = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int MAX_DUR = (MAX_A > REJECT_CYCLES) ? MAX_A : REJECT_CYCLES;
    localparam int LEN_W   = $clog2(MAX_DUR + 2);

    logic             take;
    logic [LEN_W-1:0] busy_len_q;
    logic             stat_rd_q;
    logic             seen_q;
    logic             last_tog_q;

    assign take = op_start && !busy && (op_kind != 2'b11);

    // Track the busy run length, and the toggle bit returned by status reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len_q <= '0;
            stat_rd_q  <= 1'b0;
            seen_q     <= 1'b0;
            last_tog_q <= 1'b0;
        end else begin
            busy_len_q <= busy ? ((busy_len_q == LEN_W'(MAX_DUR + 1)) ? busy_len_q
                                                                     : busy_len_q + 1'b1)
                               : '0;
            stat_rd_q  <= rd_en && busy;
            if (take) seen_q <= 1'b0;
            else if (stat_rd_q) begin
                seen_q     <= 1'b1;
                last_tog_q <= rd_data[6];
            end
        end
    end

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);                                                      // R2
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_len_q < LEN_W'(MAX_DUR)));                            // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_start) |=> $stable(run_kind));                           // R3
    AST_POLL_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && run_kind == OP_PROG) |=> (rd_data[7] == !$past(run_bit7))); // R5
    AST_POLL_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && run_kind != OP_PROG) |=> !rd_data[7]);             // R6
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_q && seen_q) |-> (rd_data[6] != last_tog_q));               // R7
    AST_TOGGLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_q && !seen_q) |-> !rd_data[6]);                             // R7

endmodule

bind flash_op_engine flash_op_checker #(
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .REJECT_CYCLES(REJECT_CYCLES)
) i_chk (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .rd_en(rd_en), .rd_data(rd_data), .busy(busy),
    .run_kind(run_kind), .run_bit7(run_data[7])
);

// File: tb/test_flash_op_engine.sv
`timescale 1ns/1ps
module test_flash_op_engine;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int PROG  = 6;
    localparam int ERASE = 20;
    localparam int REJ   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_start = 1'b0;
    logic [1:0]    op_kind = 2'b00;
    logic [AW-1:0] op_addr = '0;
    logic [7:0]    op_data = '0;
    logic          boot_lock = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;

    int  n_chk = 0;
    int  n_fail = 0;
    logic [7:0] model [DEPTH];

    always #2 clk = ~clk;

    flash_op_engine #(.ADDR_W(AW), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE),
                      .REJECT_CYCLES(REJ)) i_flash_op_engine (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .boot_lock(boot_lock),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    // Region from the requirement's map: 4 boot, 3 param 1, 2 param 2, 1 main 1, 0 main 2.
    function automatic int region(input logic [AW-1:0] a);
        int u = int'(a >> (AW - 5));
        if (u >= 30) return 4;
        if (u == 29) return 3;
        if (u == 28) return 2;
        if (u >= 16) return 1;
        return 0;
    endfunction

    // Expected array update for one completed operation.
    function automatic void apply(input int kind, input logic [AW-1:0] a,
                                  input logic [7:0] d, input bit lock);
        if (kind == 0) model[a] = model[a] & d;
        else if (kind == 1) begin
            if (!(lock && region(a) == 4))
                for (int i = 0; i < DEPTH; i++)
                    if (region(AW'(i)) == region(a)) model[i] = 8'hFF;
        end else if (kind == 2) begin
            for (int i = 0; i < DEPTH; i++)
                if (!(lock && region(AW'(i)) == 4)) model[i] = 8'hFF;
        end
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start(input int kind, input logic [AW-1:0] a, input logic [7:0] d);
        op_start = 1'b1; op_kind = 2'(kind); op_addr = a; op_data = d;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    // Full-array comparison, counted as one check.
    task automatic sweep(input string req);
        int bad = 0; int first = -1; logic [7:0] v; logic [7:0] fv = 0;
        for (int i = 0; i < DEPTH; i++) begin
            do_read(AW'(i), v);
            if (v !== model[i]) begin
                bad++;
                if (first < 0) begin first = i; fv = v; end
            end
        end
        check(bad == 0, req, (first < 0) ? 0 : int'(fv), (first < 0) ? 0 : int'(model[first]));
    endtask

    task automatic run_op(input int kind, input logic [AW-1:0] a, input logic [7:0] d,
                          output int n);
        do_start(kind, a, d);
        count_busy(n);
        apply(kind, a, d, boot_lock);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n; logic [7:0] v; logic [7:0] d; logic [AW-1:0] a; logic [AW-1:0] x;
        logic [AW-1:0] probes [7];
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(rd_data == 8'h00, "R1 reset rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 and R2: chip erase from an unknown state, with its length checked.
        run_op(2, '0, 8'h00, n);
        check(n == ERASE, "R2 erase busy length", n, ERASE);
        sweep("R11 chip erase all 0xFF");

        // R2: code 11 is not accepted.
        do_start(3, 10'h005, 8'h00);
        check(busy == 1'b0, "R2 code 11 not accepted", busy, 0);

        // R5, R7, R8: a read on every cycle of a program, one of them on the completion edge.
        a = 10'h123; d = 8'h5A;
        do_start(0, a, d);
        for (int i = 1; i <= PROG; i++) begin
            do_read(a, v);
            check(v == {~d[7], 1'((i - 1) % 2), 6'b0}, "R5/R7/R8 status during program",
                  v, {~d[7], 1'((i - 1) % 2), 6'b0});
        end
        apply(0, a, d, 1'b0);
        do_read(a, v);
        check(v == model[a], "R8 data after completion", v, model[a]);
        check(v == 8'h5A, "R4 programmed byte", v, 8'h5A);

        // R4: second program ANDs, set bit 7 gives polling bit 0.
        run_op(0, a, 8'hF3, n);
        check(n == PROG, "R2 program busy length", n, PROG);
        do_read(a, v);
        check(v == 8'h52, "R4 AND of two programs", v, 8'h52);
        d = 8'hA5; do_start(0, 10'h3FF, d);
        do_read(10'h000, v);
        check(v[7] == 1'b0, "R5 polling bit for data bit 1", v, 8'h00);
        do_read(10'h000, v);
        check(v[6] == 1'b1, "R7 toggle on second read", v, 8'h40);
        count_busy(n);
        apply(0, 10'h3FF, d, 1'b0);

        // R4: random programs across all regions, in random order.
        for (int k = 0; k < 40; k++) begin
            x = AW'($urandom); d = 8'($urandom);
            run_op(0, x, d, n);
        end
        for (int k = 0; k < 20; k++) begin
            x = AW'($urandom);
            do_read(x, v);
            check(v == model[x], "R4 random program readback", v, model[x]);
        end

        // R3: a start one cycle into an erase is ignored.
        x = 10'h210;
        run_op(0, x, 8'h0F, n);
        do_start(1, 10'h010, 8'h00);
        do_start(0, x, 8'h00);
        count_busy(n);
        apply(1, 10'h010, 8'h00, 1'b0);
        check(n + 1 == ERASE, "R3 busy length unchanged", n + 1, ERASE);
        do_read(x, v);
        check(v == model[x], "R3 ignored program left byte", v, model[x]);

        // R9 and R6: erase each region in turn, including region-boundary bytes.
        probes[0] = 10'h000; probes[1] = 10'h1FF; probes[2] = 10'h200; probes[3] = 10'h37F;
        probes[4] = 10'h380; probes[5] = 10'h3A0; probes[6] = 10'h3C0;
        for (int r = 0; r < 7; r++) run_op(0, probes[r], 8'h00, n);
        for (int r = 6; r >= 0; r--) begin
            do_start(1, probes[r], 8'h00);
            do_read(probes[r], v);
            check(v[7] == 1'b0, "R6 polling bit during sector erase", v, 8'h00);
            count_busy(n);
            apply(1, probes[r], 8'h00, 1'b0);
            if (r == 6 || r == 3 || r == 0) sweep("R9 sector erase region only");
            else begin
                for (int p = 0; p < 7; p++) begin
                    do_read(probes[p], v);
                    check(v == model[probes[p]], "R9 probe after sector erase", v, model[probes[p]]);
                end
            end
        end

        // R10: locked boot erase is rejected after a short busy.
        run_op(0, 10'h3E0, 8'h11, n);
        boot_lock = 1'b1;
        do_start(1, 10'h3F0, 8'h00);
        do_read(10'h3F0, v);
        check(v[7] == 1'b0, "R6 polling bit during rejected erase", v, 8'h00);
        count_busy(n);
        check(n + 1 == REJ, "R10 reject busy length", n + 1, REJ);
        do_read(10'h3E0, v);
        check(v == 8'h11, "R10 boot byte kept", v, 8'h11);

        // R11: a locked chip erase skips the boot region.
        run_op(0, 10'h100, 8'h22, n);
        run_op(2, '0, 8'h00, n);
        sweep("R11 locked chip erase");
        do_read(10'h3E0, v);
        check(v == 8'h11, "R11 boot byte survives locked chip erase", v, 8'h11);
        boot_lock = 1'b0;

        // R1: reset during a program aborts it with the array unchanged.
        do_start(0, 10'h050, 8'h00);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(busy == 1'b0, "R1 abort clears busy", busy, 0);
        check(rd_data == 8'h00, "R1 abort clears rd_data", rd_data, 0);
        repeat (PROG) @(negedge clk);
        do_read(10'h050, v);
        check(v == model[10'h050], "R1 aborted program wrote nothing", v, model[10'h050]);

        // Mixed random operations, with the lock set at random.
        for (int k = 0; k < 30; k++) begin
            int kind = ($urandom % 4 == 0) ? 1 : 0;
            boot_lock = 1'($urandom);
            run_op(kind, AW'($urandom), 8'($urandom), n);
            x = AW'($urandom);
            do_read(x, v);
            check(v == model[x], "R4/R9/R10 random mix readback", v, model[x]);
        end
        sweep("R9 final sweep");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule